// File: doc/BRIEF.md
# Cascadable Synchronous Binary Up Counter

This block is a small binary up counter, four bits wide by default, that advances on the rising clock edge. It has two active-low controls that act on the same edge: one clears the count and one copies a data word into it. The clear wins over the load. When neither control is active, the count advances only if two active-high enables are both high. Otherwise it holds.

The terminal-count output goes high when the count is at its maximum and the trickle enable is high. This output is combinational from the trickle enable. A chain of these counters can therefore form a wider counter with no extra gates. In a ripple chain, each stage's terminal count drives the next stage's trickle enable. In a lookahead chain, the first stage's terminal count drives the parallel enables of the later stages.

The count has no defined value until the first clear.

Top module: `casc_counter`

## Requirements
- R1: When clr_n is low at a rising edge, cnt becomes 0 after that edge, whatever ld_n, en_p, en_t and din are.
- R2: When clr_n is high and ld_n is low at a rising edge, cnt takes the value of din after that edge, whatever en_p and en_t are.
- R3: When clr_n and ld_n are both high and en_p and en_t are both high at a rising edge, cnt advances by one modulo 2^WIDTH, so the maximum value (15 for WIDTH=4, all bits 1) is followed by 0.
- R4: When clr_n and ld_n are both high and either en_p or en_t is low at a rising edge, cnt keeps its value.
- R5: term is high exactly when cnt is all ones and en_t is high. It follows en_t within the same cycle, with no clock edge in between.
- R6: term does not depend on en_p. It depends on clr_n and ld_n only through the value they give cnt.
- R7: Two instances form a 2*WIDTH-bit counter when the low stage's term drives the high stage's en_t and both stages have their other enables high. With WIDTH=4, that counter steps through all 256 values and returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the rising edge is active |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous load of din, active low |
| en_p | input | 1 | Parallel count enable, active high |
| en_t | input | 1 | Trickle count enable, active high; also gates term |
| din | input | WIDTH | Data word for a load |
| cnt | output | WIDTH | Current count |
| term | output | 1 | Terminal count: count at all ones and en_t high |

## Verification
The bench walks all sixteen combinations of the four controls from the same starting count. A design with the wrong priority between clear, load and count fails this walk. So does a design that counts on a single enable. Directed steps load the maximum value and then wrap it to 0, which catches a counter that saturates or skips a value. The bench drops en_t while the count sits at its maximum, so a design that registers term, or that gates it with en_p, shows a stale or missing terminal count. A two-stage chain run through a full 256-count cycle shows whether term carries correctly between stages.

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cnt,
  output logic             term
);

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  wire step = en_p & en_t;

  always_ff @(posedge clk) begin
    if (!clr_n)     cnt <= '0;
    else if (!ld_n) cnt <= din;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign term = en_t & (cnt == TOP);

  logic armed = 1'b0;
  always_ff @(posedge clk)
    if (!clr_n) armed <= 1'b1;

  // R1
  clear_wins_chk: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> cnt == '0);

  // R2
  load_takes_din_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && !ld_n |=> cnt == $past(din));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && ld_n && en_p && en_t |=> cnt == WIDTH'($past(cnt) + 1'b1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && ld_n && !(en_p && en_t) |=> $stable(cnt));

  // R5
  term_after_climb_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && ld_n && en_p && en_t && cnt == TOP - 1'b1 |=> term == en_t);

  // R6
  term_needs_trickle_chk: assert property (@(posedge clk) disable iff (!armed)
    term |-> en_t);

endmodule

// File: tb/casc_counter_tb.sv
module casc_counter_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       clr_n = 1'b1, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] cnt;
  logic       term;
  logic [3:0] hi_cnt;
  logic       hi_term;
  logic       hi_on = 1'b0;

  int n_chk = 0, n_fail = 0;

  casc_counter #(.WIDTH(4)) u_dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .din(din), .cnt(cnt), .term(term));

  casc_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(hi_on), .en_t(term),
    .din(4'd0), .cnt(hi_cnt), .term(hi_term));

  // {clr_n, ld_n, en_p, en_t, din[3:0], next cnt[3:0]}
  localparam int NV = 20;
  localparam logic [11:0] VEC [NV] = '{
    12'b0111_0101_0000,
    12'b1111_0000_0001,
    12'b1111_0000_0010,
    12'b1101_0000_0010,
    12'b1110_0000_0010,
    12'b1100_0000_0010,
    12'b1000_1001_1001,
    12'b1011_1110_1110,
    12'b1111_0000_1111,
    12'b1101_0000_1111,
    12'b1110_0000_1111,
    12'b1111_0000_0000,
    12'b0011_0111_0000,
    12'b1011_1111_1111,
    12'b0111_0000_0000,
    12'b1000_0011_0011,
    12'b1111_0000_0100,
    12'b1010_1111_1111,
    12'b1100_0000_1111,
    12'b0001_0000_0000
  };

  logic [3:0] model;
  logic       model_ok = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nxt(input logic [3:0] m, input logic c,
      input logic l, input logic p, input logic t, input logic [3:0] d);
    if (!c)          return 4'd0;
    else if (!l)     return d;
    else if (p && t) return m + 4'd1;
    else             return m;
  endfunction

  // called at a falling edge; checks term before and cnt after the edge
  task automatic apply(input logic c, input logic l, input logic p,
      input logic t, input logic [3:0] d, input logic [3:0] exp_next,
      input string req);
    clr_n = c; ld_n = l; en_p = p; en_t = t; din = d;
    #1;
    if (model_ok) check("R5/R6 term", term, int'(model == 4'hF && t));
    @(posedge clk);
    @(negedge clk);
    check(req, cnt, exp_next);
    model = exp_next;
    model_ok = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // table walk (R1..R6)
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      apply(v[11], v[10], v[9], v[8], v[7:4], v[3:0], "R1-table/R2/R3/R4");
    end

    // every control combination from a loaded start of 10 (R1 R2 R3 R4)
    for (int k = 0; k < 16; k++) begin
      apply(1'b1, 1'b0, 1'b0, 1'b0, 4'd10, 4'd10, "R2 preload");
      apply(k[3], k[2], k[1], k[0], 4'd6,
            nxt(4'd10, k[3], k[2], k[1], k[0], 4'd6), "R1 R2 R3 R4 combo");
    end

    // term follows en_t at count 15 with no clock edge (R5)
    apply(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 4'hF, "R2 load 15");
    en_t = 1'b1; #1; check("R5 term high", term, 1);
    en_t = 1'b0; #1; check("R5 term drops with en_t", term, 0);
    en_p = 1'b1; #1; check("R6 en_p no effect on term", term, 0);
    en_t = 1'b1; en_p = 1'b0; #1; check("R6 term with en_p low", term, 1);
    apply(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0, "R3 wrap 15 to 0");
    en_t = 1'b1; #1; check("R5 term low at 0", term, 0);

    // two-stage chain (R7)
    apply(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0, "R1 clear chain");
    check("R7 high stage cleared", hi_cnt, 0);
    hi_on = 1'b1;
    clr_n = 1'b1; ld_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    repeat (255) @(posedge clk);
    @(negedge clk);
    check("R7 chain at 255", {hi_cnt, cnt}, 255);
    check("R7 high stage term at 255", hi_term, 1);
    @(posedge clk);
    @(negedge clk);
    check("R7 chain wraps to 0", {hi_cnt, cnt}, 0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R7 chain at 40", {hi_cnt, cnt}, 40);
    en_t = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R4 chain holds", {hi_cnt, cnt}, 40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule